// File: doc/BRIEF.md
# One-Time-Programmable Store Programming Port

This block is the device-side logic that lets an external programmer write and read back a one-time-programmable program store through a narrow port with no address pins. A four-bit mode selector chooses what the port does. An 8-bit data bus carries bytes in and out. A programming clock input steps an internal word pointer. Every fourth programming-clock pulse moves the pointer to the next word, so a programmer walks the whole store in sequence after it has cleared the pointer to zero.

Each stored word is 16 bits wide and is reached one byte at a time. Where the port sits inside the current four-pulse cycle decides which byte is used. A write can only move bits from the erased state (1) to the programmed state (0). A write is ignored unless the programming voltage is present, which the block sees as a single input. The storage here is a behavioural model. The pointer always spans the full address range. The modelled array holds the low `STORE_AW` address bits, so at the default parameters higher addresses alias onto it.

All inputs are taken as synchronous to the system clock `clk`. An edge on `progClk` or on mode bit 0 is seen at the first `clk` edge after the change, and the block acts on it at that same edge.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the word pointer is 0, the pulse phase is 0, `busOe` is low and every stored word reads back as FFFFh.
- R2: The code `md` = 4'b0101 (`md[0]` is mode bit 0) clears both the word pointer and the pulse phase at the next `clk` edge. The clear wins over a `progClk` rising edge seen in the same cycle.
- R3: Each rising edge of `progClk` advances the pulse phase modulo 4. The rising edge that arrives while the phase is 2 (the third pulse of the cycle) also adds one to the word pointer. No other event moves the pointer.
- R4: The word pointer wraps from its largest value, 2^ADDR_W - 1, back to 0.
- R5: `busOe` is high only while `md` = 4'b1100. The bus is released as soon as mode bit 0 rises.
- R6: `busOut` always presents one byte of the addressed word: bits 7:0 while the phase is 0 or 1, and bits 15:8 while the phase is 2 or 3.
- R7: With `md[3:1]` = 3'b111, a fall of mode bit 0 (4'b1111 to 4'b1110) writes `busIn` into the byte chosen by R6. The write uses the pointer and phase held before any pointer or phase change in that same cycle.
- R8: A write strobe that arrives while `vppOk` is low leaves the stored data unchanged.
- R9: A write ANDs `busIn` into the stored byte. Bits that are already 0 never return to 1.
- R10: A fall of mode bit 0 under any other code (for example 4'b0111 to 4'b0110) writes nothing. Codes other than 4'b1100 never drive the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| progClk | input | 1 | Programming clock that steps the pulse phase and the word pointer |
| md | input | 4 | Mode selector, bit 0 also acts as the write strobe |
| vppOk | input | 1 | High while the programming voltage is present |
| busIn | input | 8 | Byte presented by the programmer |
| busOut | output | 8 | Selected byte of the addressed word |
| busOe | output | 1 | Drive enable for the external data bus |

## Verification
Two collisions are forced on purpose. In the first, a write strobe, made by a fall of mode bit 0, arrives in the same cycle as the third `progClk` rise. The bench then reads the old word back to confirm that the byte landed at the pointer and phase held before the step. In the second, the clear code arrives together with a `progClk` rise while the phase is 2. The bench then confirms that the pointer and phase are both zero and that no step took place. The reference model applies the write before the pointer update and lets the clear override the step. Every cycle it compares `busOe` and `busOut` against the model, and that comparison decides whether each collision passes.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned PHASES = 4;
  localparam int unsigned PHASE_W = $clog2(PHASES);
  localparam logic [PHASE_W-1:0] STEP_PHASE = PHASE_W'(2);
  localparam logic [MODE_W-1:0] MD_CLEAR = 4'b0101;
  localparam logic [MODE_W-1:0] MD_VERIFY = 4'b1100;
  localparam logic [MODE_W-2:0] MD_WRITE_HI = 3'b111;

  typedef struct packed {
    logic clrAddr;
    logic stepAddr;
    logic wrByte;
    logic hiSel;
    logic drive;
  } otpStrobes_t;
endpackage

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                progClk,
  input  logic [MODE_W-1:0]   md,
  input  logic                vppOk,
  output otpStrobes_t         stb,
  output logic [PHASE_W-1:0]  phase
);
  logic progQ;
  logic md0Q;
  logic progRise;
  logic clearMode;
  logic writeFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progQ <= 1'b0;
      md0Q  <= 1'b0;
    end else begin
      progQ <= progClk;
      md0Q  <= md[0];
    end
  end

  assign progRise  = progClk & ~progQ;
  assign clearMode = (md == MD_CLEAR);
  assign writeFall = (md[MODE_W-1:1] == MD_WRITE_HI) && !md[0] && md0Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (clearMode) begin
      phase <= '0;
    end else if (progRise) begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    stb.clrAddr  = clearMode;
    stb.stepAddr = !clearMode && progRise && (phase == STEP_PHASE);
    stb.wrByte   = writeFall && vppOk;
    stb.hiSel    = phase[PHASE_W-1];
    stb.drive    = (md == MD_VERIFY);
  end
endmodule

// File: rtl/otp_prog_datapath.sv
module otp_prog_datapath
  import otp_prog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned STORE_AW = 10,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  otpStrobes_t        stb,
  input  logic [BYTE_W-1:0]  busIn,
  output logic [BYTE_W-1:0]  busOut,
  output logic [ADDR_W-1:0]  addrQ
);
  localparam int unsigned LANES = 2;
  localparam int unsigned DEPTH = 1 << STORE_AW;

  logic [STORE_AW-1:0] idx;
  logic [BYTE_W-1:0]   laneRd [LANES];

  assign idx = addrQ[STORE_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.clrAddr) begin
      addrQ <= '0;
    end else if (stb.stepAddr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic LANE_HI = (b == 1);
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) begin
          cells[i] <= '1;
        end
      end else if (stb.wrByte && (stb.hiSel == LANE_HI)) begin
        cells[idx] <= cells[idx] & busIn;
      end
    end

    assign laneRd[b] = cells[idx];
  end

  assign busOut = stb.hiSel ? laneRd[1] : laneRd[0];
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_prog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned STORE_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progClk,
  input  logic [3:0]  md,
  input  logic        vppOk,
  input  logic [7:0]  busIn,
  output logic [7:0]  busOut,
  output logic        busOe
);
  otpStrobes_t          stb;
  logic [PHASE_W-1:0]   curPhase;
  logic [ADDR_W-1:0]    curAddr;

  otp_prog_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .progClk (progClk),
    .md      (md),
    .vppOk   (vppOk),
    .stb     (stb),
    .phase   (curPhase)
  );

  otp_prog_datapath #(
    .ADDR_W   (ADDR_W),
    .STORE_AW (STORE_AW),
    .BYTE_W   (8)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .busIn  (busIn),
    .busOut (busOut),
    .addrQ  (curAddr)
  );

  assign busOe = stb.drive;
endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk
  import otp_prog_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               progClk,
  input logic [3:0]         md,
  input logic               vppOk,
  input logic               busOe,
  input otpStrobes_t        stb,
  input logic [PHASE_W-1:0] curPhase,
  input logic [ADDR_W-1:0]  curAddr
);
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    (md == MD_CLEAR) |=> (curAddr == '0 && curPhase == '0));

  a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepAddr |=> (curAddr == $past(curAddr) + 1'b1));

  a_r3_step_needs_clock: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepAddr |-> (progClk && curPhase == STEP_PHASE));

  a_r3_pointer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepAddr && !stb.clrAddr) |=> $stable(curAddr));

  a_r5_drive_needs_group: assert property (@(posedge clk) disable iff (!rstN)
    !(md[3] && md[2]) |-> !busOe);

  a_r5_release_on_md0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(md[0]) |-> !busOe);

  a_r8_no_write_without_vpp: assert property (@(posedge clk) disable iff (!rstN)
    !vppOk |-> !stb.wrByte);

  a_r10_write_needs_code: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |-> (md[3] && md[2] && md[1] && !md[0]));
endmodule

bind otp_prog_port otp_prog_port_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .progClk  (progClk),
  .md       (md),
  .vppOk    (vppOk),
  .busOe    (busOe),
  .stb      (stb),
  .curPhase (curPhase),
  .curAddr  (curAddr)
);

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb_top;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progClk = 1'b0;
  logic [3:0] mdSel = 4'b1111;
  logic       vppOk = 1'b1;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic       busOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] refMem [DEPTH];
  int refAddr = 0;
  int refPhase = 0;
  logic prevP = 1'b0;
  logic prevMd0 = 1'b0;

  always #10 clk = ~clk;

  otp_prog_port #(.ADDR_W(AW), .STORE_AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .progClk(progClk), .md(mdSel),
    .vppOk(vppOk), .busIn(busIn), .busOut(busOut), .busOe(busOe)
  );

  task automatic compare(input string tag);
    logic       expOe;
    logic [7:0] expOut;
    expOe  = (mdSel == 4'b1100);
    expOut = (refPhase >= 2) ? refMem[refAddr][15:8] : refMem[refAddr][7:0];
    checks++;
    if (busOe !== expOe) begin
      failures++;
      $display("FAIL %s busOe actual=%b expected=%b", tag, busOe, expOe);
    end
    checks++;
    if (busOut !== expOut) begin
      failures++;
      $display("FAIL %s busOut actual=%h expected=%h (addr %0d phase %0d)",
               tag, busOut, expOut, refAddr, refPhase);
    end
  endtask

  task automatic tick(input string tag);
    logic rise;
    logic fall0;
    @(posedge clk);
    rise  = progClk && !prevP;
    fall0 = !mdSel[0] && prevMd0;
    if (vppOk && mdSel[3:1] == 3'b111 && fall0) begin
      if (refPhase >= 2) refMem[refAddr][15:8] = refMem[refAddr][15:8] & busIn;
      else refMem[refAddr][7:0] = refMem[refAddr][7:0] & busIn;
    end
    if (mdSel == 4'b0101) begin
      refAddr = 0;
      refPhase = 0;
    end else if (rise) begin
      if (refPhase == 2) refAddr = (refAddr + 1) % DEPTH;
      refPhase = (refPhase + 1) % 4;
    end
    prevP = progClk;
    prevMd0 = mdSel[0];
    @(negedge clk);
    compare(tag);
  endtask

  task automatic pulse(input string tag);
    progClk = 1'b1;
    tick(tag);
    progClk = 1'b0;
    tick(tag);
  endtask

  task automatic doWrite(input logic [7:0] data, input string tag);
    mdSel = 4'b1111;
    tick(tag);
    busIn = data;
    mdSel = 4'b1110;
    tick(tag);
    mdSel = 4'b1111;
    tick(tag);
  endtask

  task automatic readBack(input string tag);
    mdSel = 4'b1100;
    tick(tag);
    mdSel = 4'b1101;
    tick(tag);
    mdSel = 4'b1111;
    tick(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rstN = 1'b1;
    tick("R1");
    for (int i = 0; i < 4; i++) pulse("R1 erased read");

    mdSel = 4'b0101;
    tick("R2 clear");
    mdSel = 4'b1111;
    tick("R2");

    doWrite(8'hA5, "R7 low byte write");
    readBack("R5 verify drive and release");

    pulse("R6");
    pulse("R6 to high phase");
    doWrite(8'h3C, "R7 high byte write");
    readBack("R6 high byte read");

    vppOk = 1'b0;
    doWrite(8'h00, "R8 no vpp");
    vppOk = 1'b1;
    readBack("R8 unchanged");

    doWrite(8'hFF, "R9 ones keep zeros");
    doWrite(8'h0F, "R9 and into byte");
    readBack("R9 readback");

    mdSel = 4'b0111; tick("R10");
    mdSel = 4'b0110; tick("R10 fall outside write code");
    mdSel = 4'b1101; tick("R10 no drive");
    mdSel = 4'b0100; tick("R10");
    mdSel = 4'b1000; tick("R10");
    mdSel = 4'b1111; tick("R10");
    readBack("R10 readback");

    busIn = 8'h81;
    mdSel = 4'b1110;
    progClk = 1'b1;
    tick("R7 write with step edge");
    progClk = 1'b0;
    mdSel = 4'b1111;
    tick("R7");
    pulse("R3"); pulse("R3"); pulse("R3");
    mdSel = 4'b0101;
    progClk = 1'b1;
    tick("R2 clear beats step");
    progClk = 1'b0;
    mdSel = 4'b1111;
    tick("R2");
    pulse("R7 old word check"); pulse("R7 old word check");
    readBack("R7 collision readback");
    mdSel = 4'b0101; tick("R2"); mdSel = 4'b1111; tick("R2");

    for (int w = 0; w < 6; w++) begin
      doWrite(8'(w * 17 + 3), "R3 per word write");
      for (int p = 0; p < 4; p++) pulse("R3 stepping");
    end

    for (int p = 0; p < 4 * DEPTH; p++) pulse("R4 wrap");
    readBack("R4 after wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule